// File: doc/BRIEF.md
# Key Reconciliation Parity Responder

This block is the on-chip half of an interactive error-correction exchange for a 128-bit response taken from a physical unclonable function. The response is shifted in serially and kept in a register. A remote server, which owns the reference response and all decisions, asks for parities: it names the members of a block one 7-bit index per cycle, and the block answers with the XOR of the addressed response bits. The server compares that answer with its own reference parity. An odd relative parity sends it into a binary search over halves of the block, and then into backtracking over earlier blocks.

Block membership is chosen freely by the server and is reshuffled between passes, so the indexes of one request can arrive in any order and need not be adjacent. Once the server has located an erroneous bit, it sends a flip command that inverts that bit in place. Later parity requests then see the corrected value. A clear command abandons a partially sent block. All search and backtracking logic stays off-chip. The device holds only the response register, a bit selector and a one-bit accumulator.

Top module: `recon_parity_resp`

## Requirements
- R1: After reset the response register holds all zeros, the accumulator is zero and `par_valid` is low.
- R2: While `load_en` is high, each cycle shifts `load_bit` into index 0 and moves every bit up one index. After 128 load cycles, the bit loaded in load cycle k (k = 0 first) sits at index 127 - k.
- R3: A command with `cmd_op` = 2'b00 adds the response bit at `cmd_idx` to the running parity. A command with `cmd_op` = 2'b01 adds its bit and closes the block. In the following cycle `par_valid` is high and `par_bit` equals the XOR of every bit named in that block.
- R4: Indexes within one block may arrive in any order and may be non-adjacent. An index named twice contributes twice, so the two contributions cancel.
- R5: `par_valid` is high for exactly one cycle per closed block, and only in the cycle after a 2'b01 command. The next block starts from a zero parity, and two closing commands on consecutive cycles give two consecutive results.
- R6: A command with `cmd_op` = 2'b10 inverts only the response bit at `cmd_idx`. It produces no result and leaves the running parity of an open block unchanged.
- R7: A command with `cmd_op` = 2'b11 resets the running parity to zero without producing a result.
- R8: While `load_en` is high, commands are ignored. They produce no result, flip no bit and leave the running parity unchanged.
- R9: Blocks of 1, 4, 8, 16 and 32 members, including shuffled ones, return correct parities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Serial response load enable |
| load_bit | input | 1 | Serial response bit, first bit ends at the top index |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 member, 01 last member, 10 flip bit, 11 clear parity |
| cmd_idx | input | 7 | Response bit index for the command |
| par_valid | output | 1 | One-cycle result strobe |
| par_bit | output | 1 | Block parity, valid with `par_valid` |

## Verification
Every command takes effect at the clock edge that samples it. A block's parity shows up on `par_valid`/`par_bit` in the cycle after its closing command, and a flip becomes visible to any parity request issued from the next cycle on. The bench drives inputs on falling edges and compares the outputs at the next falling edge against a bit-level model updated once per rising edge, so every output is checked exactly one register stage after its stimulus. Effects that have no output of their own, such as a flip, a clear or an ignored command during load, are checked through later single-bit or multi-bit parity requests.

// File: rtl/recon_pkg.sv
package recon_pkg;
    typedef enum logic [1:0] {
        OP_MEMBER = 2'b00,
        OP_LAST   = 2'b01,
        OP_FLIP   = 2'b10,
        OP_CLEAR  = 2'b11
    } op_e;
endpackage

// File: rtl/recon_resp_reg.sv
// Response register: serial load from index 0 upward, in-place single-bit flip.
module recon_resp_reg #(
    parameter int W     = 128,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             flip_en,
    input  logic [IDX_W-1:0] flip_idx,
    output logic [W-1:0]     resp_q
);
    typedef struct packed {
        logic [W-1:0] resp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.resp = {st_q.resp[W-2:0], shift_bit};
        end else if (flip_en) begin
            st_d.resp[flip_idx] = ~st_q.resp[flip_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_q = st_q.resp;

    // R2: newest serial bit lands at index 0
    p_load_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(shift_en) |-> resp_q[0] == $past(shift_bit));

    // R6: a flip changes exactly one bit
    p_flip_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(flip_en) && !$past(shift_en)
        |-> $countones(resp_q ^ $past(resp_q)) == 1);

    // R6/R8: no stimulus, no change
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(flip_en) && !$past(shift_en) |-> $stable(resp_q));
endmodule

// File: rtl/recon_bit_sel.sv
// Two-level W:1 selector: LEAF_W:1 within each group, then group select.
module recon_bit_sel #(
    parameter int W      = 128,
    parameter int LEAF_W = 8,
    parameter int IDX_W  = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam int GROUPS = W / LEAF_W;
    localparam int LOW_W  = $clog2(LEAF_W);
    localparam int HIGH_W = IDX_W - LOW_W;

    logic [GROUPS-1:0] leaf_bits;
    logic [LOW_W-1:0]  lo_idx;
    logic [HIGH_W-1:0] hi_idx;

    assign lo_idx = idx[LOW_W-1:0];
    assign hi_idx = idx[IDX_W-1:LOW_W];

    for (genvar g = 0; g < GROUPS; g++) begin : g_leaf
        logic [LEAF_W-1:0] slice;
        assign slice        = vec[g*LEAF_W +: LEAF_W];
        assign leaf_bits[g] = slice[lo_idx];
    end

    assign bit_o = leaf_bits[hi_idx];
endmodule

// File: rtl/recon_cmd_dec.sv
// Command decode: qualifies commands with valid and blocks them during load.
module recon_cmd_dec
    import recon_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       load_en,
    output logic       acc_en,
    output logic       last_en,
    output logic       flip_en,
    output logic       clr_en
);
    logic live;
    op_e  op;

    always_comb begin
        live    = cmd_valid && !load_en;
        op      = op_e'(cmd_op);
        acc_en  = 1'b0;
        last_en = 1'b0;
        flip_en = 1'b0;
        clr_en  = 1'b0;
        if (live) begin
            unique case (op)
                OP_MEMBER: acc_en  = 1'b1;
                OP_LAST:   last_en = 1'b1;
                OP_FLIP:   flip_en = 1'b1;
                OP_CLEAR:  clr_en  = 1'b1;
                default:   ;
            endcase
        end
    end

    always_comb begin
        a_onehot_r8: assert ($onehot0({acc_en, last_en, flip_en, clr_en}));
    end
endmodule

// File: rtl/recon_parity_acc.sv
// One-bit parity accumulator with registered result strobe.
module recon_parity_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_bit,
    input  logic acc_en,
    input  logic last_en,
    input  logic clr_en,
    output logic par_valid,
    output logic par_bit
);
    typedef struct packed {
        logic acc;
        logic vld;
        logic res;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr_en) begin
            st_d.acc = 1'b0;
        end else if (last_en) begin
            st_d.res = st_q.acc ^ sel_bit;
            st_d.vld = 1'b1;
            st_d.acc = 1'b0;
        end else if (acc_en) begin
            st_d.acc = st_q.acc ^ sel_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_valid = st_q.vld;
    assign par_bit   = st_q.res;

    // R5: result strobe only after a closing command
    p_strobe_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> $past(rst_n) && $past(last_en));

    // R5: result holds between strobes
    p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !par_valid |-> $stable(par_bit));
endmodule

// File: rtl/recon_parity_resp.sv
module recon_parity_resp #(
    parameter int RESP_W = 128,
    parameter int LEAF_W = 8,
    parameter int IDX_W  = $clog2(RESP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             load_bit,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    output logic             par_valid,
    output logic             par_bit
);
    logic              acc_en, last_en, flip_en, clr_en;
    logic [RESP_W-1:0] resp;
    logic              sel_bit;

    recon_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .load_en   (load_en),
        .acc_en    (acc_en),
        .last_en   (last_en),
        .flip_en   (flip_en),
        .clr_en    (clr_en)
    );

    recon_resp_reg #(.W(RESP_W), .IDX_W(IDX_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (load_en),
        .shift_bit (load_bit),
        .flip_en   (flip_en),
        .flip_idx  (cmd_idx),
        .resp_q    (resp)
    );

    recon_bit_sel #(.W(RESP_W), .LEAF_W(LEAF_W), .IDX_W(IDX_W)) u_sel (
        .vec   (resp),
        .idx   (cmd_idx),
        .bit_o (sel_bit)
    );

    recon_parity_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_bit   (sel_bit),
        .acc_en    (acc_en),
        .last_en   (last_en),
        .clr_en    (clr_en),
        .par_valid (par_valid),
        .par_bit   (par_bit)
    );

    // R3: a result follows a live closing command at the ports
    p_result_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cmd_valid && cmd_op == 2'b01 && !load_en) |-> par_valid);

    // R8: no result after a load cycle
    p_quiet_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load_en) |-> !par_valid);

    // R1: reset leaves the result strobe low
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !par_valid);
endmodule

// File: tb/recon_parity_resp_tb.sv
module recon_parity_resp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic       load_bit = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [6:0] cmd_idx = '0;
    logic       par_valid;
    logic       par_bit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [W-1:0] m_resp = '0;
    logic         m_acc  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    recon_parity_resp u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bit(load_bit),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .par_valid(par_valid), .par_bit(par_bit)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic step(input logic v, input logic [1:0] op, input logic [6:0] idx,
                        input logic ld, input logic lb, input string tag);
        logic ev, eb;
        load_en = ld; load_bit = lb; cmd_valid = v; cmd_op = op; cmd_idx = idx;
        @(posedge clk);
        ev = 1'b0; eb = 1'b0;
        if (ld) begin
            m_resp = {m_resp[W-2:0], lb};
        end else if (v) begin
            case (op)
                2'b00: m_acc = m_acc ^ m_resp[idx];
                2'b01: begin ev = 1'b1; eb = m_acc ^ m_resp[idx]; m_acc = 1'b0; end
                2'b10: m_resp[idx] = ~m_resp[idx];
                default: m_acc = 1'b0;
            endcase
        end
        @(negedge clk);
        check(par_valid, ev, tag, "par_valid");
        if (ev) check(par_bit, eb, tag, "par_bit");
        load_en = 1'b0; cmd_valid = 1'b0;
    endtask

    function automatic logic [6:0] shuf(input int i);
        return 7'(((i * 37) + 11) % W);
    endfunction

    task automatic block(input int n, input int start, input bit shuffled, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [6:0] ix;
            ix = shuffled ? shuf(start + i) : 7'((start + i) % W);
            step(1'b1, (i == n - 1) ? 2'b01 : 2'b00, ix, 1'b0, 1'b0, tag);
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'b00, 7'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic load_pattern(input int seed, input bit with_cmds, input string tag);
        for (int k = 0; k < W; k++) begin
            logic b;
            b = ((k * seed) % 7 < 3) ^ k[4];
            step(with_cmds, 2'(k % 4), 7'(k), 1'b1, b, tag);
        end
    endtask

    task automatic t_reset;
        check(par_valid, 1'b0, "R1", "par_valid in reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(par_valid, 1'b0, "R1", "par_valid after reset");
        block(8, 0, 1'b0, "R1");
        block(8, 120, 1'b0, "R1");
    endtask

    task automatic t_load;
        load_pattern(5, 1'b0, "R2");
        // single-bit probes of load order
        for (int k = 0; k < W; k += 9) block(1, k, 1'b0, "R2");
        block(1, 127, 1'b0, "R2");
    endtask

    task automatic t_sizes;
        block(4, 0, 1'b0, "R3");
        block(4, 60, 1'b0, "R9");
        block(8, 3, 1'b1, "R9");
        block(16, 40, 1'b1, "R9");
        block(32, 70, 1'b1, "R9");
        block(1, 77, 1'b1, "R9");
    endtask

    task automatic t_order;
        // reversed, scattered, and duplicated members
        step(1'b1, 2'b00, 7'd100, 1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 7'd2,   1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 7'd63,  1'b0, 1'b0, "R4");
        step(1'b1, 2'b01, 7'd17,  1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 7'd45,  1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 7'd45,  1'b0, 1'b0, "R4");
        step(1'b1, 2'b01, 7'd9,   1'b0, 1'b0, "R4");
    endtask

    task automatic t_pulse;
        // back-to-back closings, then silence
        step(1'b1, 2'b01, 7'd5,  1'b0, 1'b0, "R5");
        step(1'b1, 2'b01, 7'd6,  1'b0, 1'b0, "R5");
        step(1'b1, 2'b01, 7'd7,  1'b0, 1'b0, "R5");
        idle("R5");
        idle("R5");
    endtask

    task automatic t_flip;
        block(1, 30, 1'b0, "R6");
        step(1'b1, 2'b10, 7'd30, 1'b0, 1'b0, "R6");
        block(1, 30, 1'b0, "R6");
        block(1, 31, 1'b0, "R6");
        block(1, 29, 1'b0, "R6");
        // flip in the middle of an open block
        step(1'b1, 2'b00, 7'd90, 1'b0, 1'b0, "R6");
        step(1'b1, 2'b10, 7'd91, 1'b0, 1'b0, "R6");
        step(1'b1, 2'b01, 7'd91, 1'b0, 1'b0, "R6");
        block(8, 88, 1'b0, "R6");
    endtask

    task automatic t_clear;
        step(1'b1, 2'b00, 7'd10, 1'b0, 1'b0, "R7");
        step(1'b1, 2'b00, 7'd11, 1'b0, 1'b0, "R7");
        step(1'b1, 2'b11, 7'd0,  1'b0, 1'b0, "R7");
        step(1'b1, 2'b01, 7'd12, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_load_ignore;
        // open a block, then load with commands present on every cycle
        for (int i = 0; i < W; i++) begin
            if (m_resp[i]) begin
                step(1'b1, 2'b00, 7'(i), 1'b0, 1'b0, "R8");
                break;
            end
        end
        load_pattern(3, 1'b1, "R8");
        block(1, 0, 1'b0, "R8");
        for (int k = 1; k < W; k += 13) block(1, k, 1'b0, "R8");
        block(32, 0, 1'b1, "R8");
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_sizes();
        t_order();
        t_pulse();
        t_flip();
        t_clear();
        t_load_ignore();
        summary();
    end
endmodule